// File: doc/BRIEF.md
# Dual-Slot Bundle Sequencer Control

This block is the instruction-flow controller of a vector coprocessor. The coprocessor executes 64-bit bundles. Each bundle pairs an upper-slot word (bits 63:32) with a lower-slot word (bits 31:0). The controller holds the program counter and presents it on a combinational read port of the local micro-memory. Each cycle it is running, it issues the bundle that comes back. The top five bits of the upper word are control flags. The controller acts on them itself: it captures immediates, ends the program with a delay slot, raises debug and trap events, and keeps a sticky marker.

The lower slot reports a taken branch through a request and target pair. The controller redirects the program counter only after one delay-slot bundle has issued. A second branch in that delay slot is queued behind the first. The controller also decides whether the lower word of the current bundle executes at all. A start request, accepted only while idle, launches a program. The end flag stops it one bundle later.

Top module: `useq_ctrl`

## Requirements
- R1: While running, exactly one bundle issues per clock cycle. Unless a branch redirects, the program counter advances by 8 each cycle. The program counter is always a multiple of 8.
- R2: Upper-word bit 31 is the immediate flag. When an issued bundle has it set, the lower word is copied to `imm_o` on the next cycle, `lower_exec_o` is low for that bundle, and any branch request during that bundle is ignored.
- R3: Upper-word bit 30 is the end flag. The bundle that follows it still issues, and `running_o` falls after that bundle. No further bundle issues.
- R4: Upper-word bit 28 is the debug flag. When it is issued with `flag_en_i[0]` set, `dbg_stat_o` becomes set and `irq_o` pulses high for one cycle on the cycle after issue. With `flag_en_i[0]` clear, the flag does nothing.
- R5: Upper-word bit 27 is the trap flag. It behaves like R4, but uses `flag_en_i[1]` and `trap_stat_o`.
- R6: A branch request during a bundle at address A (lower slot executing) lets A+8 issue. The bundle after that is the branch target.
- R7: When a second branch is requested in the first branch's delay slot, the first target issues, and then the second target.
- R8: Upper-word bit 29 sets `marker_o`. The marker stays set until `stat_clr_i[2]` is pulsed, including after the program ends.
- R9: A start request while idle loads the program counter from `start_addr_i` with bits 2:0 forced to zero and sets `running_o`. The start address issues on the following cycle.
- R10: A start request while running has no effect on the sequence of issued addresses.
- R11: `stat_clr_i[0]` clears `dbg_stat_o` and `stat_clr_i[1]` clears `trap_stat_o`, each independently. A new event in the same cycle as a clear wins over the clear.
- R12: The program counter wraps modulo 2^PC_W, so the bundle at the highest address is followed by address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch request |
| start_addr_i | input | PC_W | Byte address of the first bundle |
| flag_en_i | input | 2 | Event enables: bit 0 debug, bit 1 trap |
| stat_clr_i | input | 3 | Write-one-to-clear: bit 0 debug, bit 1 trap, bit 2 marker |
| branch_i | input | 1 | Lower slot requests a taken branch for the current bundle |
| branch_tgt_i | input | PC_W | Branch target byte address |
| mem_addr_o | output | PC_W | Micro-memory read address (program counter) |
| mem_data_i | input | 64 | Bundle read at mem_addr_o |
| lower_exec_o | output | 1 | Lower word of the current bundle executes as an instruction |
| running_o | output | 1 | Sequencer is issuing bundles |
| irq_o | output | 1 | Interrupt pulse for a debug or trap event |
| dbg_stat_o | output | 1 | Sticky debug status |
| trap_stat_o | output | 1 | Sticky trap status |
| marker_o | output | 1 | Sticky marker flag |
| imm_o | output | 32 | Immediate register |

## Verification
The bench builds the controller with PC_W = 12, which gives a 512-bundle micro-memory the bench can model directly. With that width, a program placed at the top of the address space runs into the wrap to address 0 within a few cycles. The bench drives branch requests from a per-address table, so branches in delay slots, branches hidden behind the immediate flag, and end markers landing on branch targets are all placed at fixed addresses. Each scenario is then checked against the exact expected order of issued addresses.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int unsigned IMM_BIT  = 31;
  localparam int unsigned END_BIT  = 30;
  localparam int unsigned MARK_BIT = 29;
  localparam int unsigned DBG_BIT  = 28;
  localparam int unsigned TRAP_BIT = 27;

  typedef struct packed {
    logic imm;
    logic fin;
    logic mark;
    logic dbg;
    logic trap;
  } ctl_flags_t;

  function automatic ctl_flags_t decode_flags(input logic [31:0] upper);
    ctl_flags_t f;
    f.imm  = upper[IMM_BIT];
    f.fin  = upper[END_BIT];
    f.mark = upper[MARK_BIT];
    f.dbg  = upper[DBG_BIT];
    f.trap = upper[TRAP_BIT];
    return f;
  endfunction

endpackage

// File: rtl/useq_branch.sv
module useq_branch #(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            issue,
  input  logic            take,
  input  logic [PC_W-1:0] tgt,
  output logic            redirect,
  output logic [PC_W-1:0] redir_pc
);
  logic            armed_q;
  logic [PC_W-1:0] tgt_q;

  // An armed target applies at the next issued bundle (the delay slot).
  // A branch inside that slot re-arms with its own target at the same edge.
  assign redirect = issue & armed_q;
  assign redir_pc = tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tgt_q   <= '0;
    end else if (flush) begin
      armed_q <= 1'b0;
    end else if (issue) begin
      if (take) begin
        armed_q <= 1'b1;
        tgt_q   <= {tgt[PC_W-1:3], 3'b000};
      end else begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/useq_status.sv
module useq_status (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue,
  input  useq_pkg::ctl_flags_t  flags,
  input  logic [1:0]            en,
  input  logic [2:0]            clr,
  output logic                  dbg_hit,
  output logic                  trap_hit,
  output logic                  dbg_stat,
  output logic                  trap_stat,
  output logic                  marker,
  output logic                  irq
);
  logic mark_hit;

  assign dbg_hit  = issue & flags.dbg  & en[0];
  assign trap_hit = issue & flags.trap & en[1];
  assign mark_hit = issue & flags.mark;

  // Sticky bit update: set wins over a clear in the same cycle.
  function automatic logic sticky(input logic cur, input logic c, input logic s);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_stat  <= 1'b0;
      trap_stat <= 1'b0;
      marker    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      dbg_stat  <= sticky(dbg_stat,  clr[0], dbg_hit);
      trap_stat <= sticky(trap_stat, clr[1], trap_hit);
      marker    <= sticky(marker,    clr[2], mark_hit);
      irq       <= dbg_hit | trap_hit;
    end
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_addr_i,
  input  logic [1:0]      flag_en_i,
  input  logic [2:0]      stat_clr_i,
  input  logic            branch_i,
  input  logic [PC_W-1:0] branch_tgt_i,
  output logic [PC_W-1:0] mem_addr_o,
  input  logic [63:0]     mem_data_i,
  output logic            lower_exec_o,
  output logic            running_o,
  output logic            irq_o,
  output logic            dbg_stat_o,
  output logic            trap_stat_o,
  output logic            marker_o,
  output logic [31:0]     imm_o
);
  import useq_pkg::*;

  localparam int unsigned STEP = 8;

  logic [PC_W-1:0] pc_q;
  logic            run_q;
  logic            end_arm_q;
  logic [31:0]     imm_q;

  ctl_flags_t      flags_w;
  logic            issue_w;
  logic            start_ok_w;
  logic            stop_w;
  logic            imm_hit_w;
  logic            take_w;
  logic            redirect_w;
  logic [PC_W-1:0] redir_pc_w;
  logic            dbg_hit_w;
  logic            trap_hit_w;

  function automatic logic [PC_W-1:0] step_pc(input logic [PC_W-1:0] p);
    return p + PC_W'(STEP);
  endfunction

  function automatic logic [PC_W-1:0] align_pc(input logic [PC_W-1:0] p);
    return {p[PC_W-1:3], 3'b000};
  endfunction

  assign flags_w    = decode_flags(mem_data_i[63:32]);
  assign issue_w    = run_q;
  assign start_ok_w = start_i & ~run_q;
  assign stop_w     = issue_w & end_arm_q;
  assign imm_hit_w  = issue_w & flags_w.imm;
  assign take_w     = issue_w & ~flags_w.imm & branch_i;

  useq_branch #(.PC_W(PC_W)) branch_i0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (start_ok_w | stop_w),
    .issue    (issue_w),
    .take     (take_w),
    .tgt      (branch_tgt_i),
    .redirect (redirect_w),
    .redir_pc (redir_pc_w)
  );

  useq_status status_i0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue_w),
    .flags     (flags_w),
    .en        (flag_en_i),
    .clr       (stat_clr_i),
    .dbg_hit   (dbg_hit_w),
    .trap_hit  (trap_hit_w),
    .dbg_stat  (dbg_stat_o),
    .trap_stat (trap_stat_o),
    .marker    (marker_o),
    .irq       (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= '0;
      run_q     <= 1'b0;
      end_arm_q <= 1'b0;
      imm_q     <= '0;
    end else if (start_ok_w) begin
      pc_q      <= align_pc(start_addr_i);
      run_q     <= 1'b1;
      end_arm_q <= 1'b0;
    end else if (issue_w) begin
      pc_q <= redirect_w ? redir_pc_w : step_pc(pc_q);
      if (end_arm_q) begin
        run_q     <= 1'b0;
        end_arm_q <= 1'b0;
      end else if (flags_w.fin) begin
        end_arm_q <= 1'b1;
      end
      if (imm_hit_w) imm_q <= mem_data_i[31:0];
    end
  end

  assign mem_addr_o   = pc_q;
  assign running_o    = run_q;
  assign lower_exec_o = issue_w & ~flags_w.imm;
  assign imm_o        = imm_q;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            running_o,
  input logic [PC_W-1:0] mem_addr_o,
  input logic            irq_o,
  input logic            dbg_stat_o,
  input logic            trap_stat_o,
  input logic [31:0]     imm_o,
  input logic            redirect_w,
  input logic            end_arm_q,
  input logic            dbg_hit_w,
  input logic            trap_hit_w,
  input logic            imm_hit_w
);
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && $past(running_o) && !$past(redirect_w))
      |-> mem_addr_o == $past(mem_addr_o) + PC_W'(8));

  assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> mem_addr_o[2:0] == 3'b000);

  assert_imm_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_o != $past(imm_o)) |-> $past(imm_hit_w));

  assert_end_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> $past(end_arm_q));

  assert_dbg_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_stat_o && !$past(dbg_stat_o)) |-> $past(dbg_hit_w));

  assert_trap_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_stat_o && !$past(trap_stat_o)) |-> $past(trap_hit_w));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running_o) && $past(start_i) && running_o && !$past(redirect_w))
      |-> mem_addr_o == $past(mem_addr_o) + PC_W'(8));

  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(dbg_hit_w) || $past(trap_hit_w)));
endmodule

bind useq_ctrl useq_ctrl_chk #(.PC_W(PC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .running_o   (running_o),
  .mem_addr_o  (mem_addr_o),
  .irq_o       (irq_o),
  .dbg_stat_o  (dbg_stat_o),
  .trap_stat_o (trap_stat_o),
  .imm_o       (imm_o),
  .redirect_w  (redirect_w),
  .end_arm_q   (end_arm_q),
  .dbg_hit_w   (dbg_hit_w),
  .trap_hit_w  (trap_hit_w),
  .imm_hit_w   (imm_hit_w)
);

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb_top;
  localparam int unsigned PC_W = 12;
  localparam int unsigned NB   = 512;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [PC_W-1:0] start_addr_i = '0;
  logic [1:0]      flag_en_i = 2'b00;
  logic [2:0]      stat_clr_i = 3'b000;
  logic            branch_i;
  logic [PC_W-1:0] branch_tgt_i;
  logic [PC_W-1:0] mem_addr_o;
  logic [63:0]     mem_data_i;
  logic            lower_exec_o, running_o, irq_o, dbg_stat_o, trap_stat_o, marker_o;
  logic [31:0]     imm_o;

  logic [63:0]     mem  [NB];
  logic            br_v [NB];
  logic [PC_W-1:0] br_t [NB];

  int checks = 0, fails = 0;
  int tn = 0, irq_cnt = 0;
  logic [PC_W-1:0] tr [32];
  logic            lx [32];
  logic [PC_W-1:0] ex [8];

  always #5 clk = ~clk;

  assign mem_data_i   = mem[mem_addr_o[PC_W-1:3]];
  assign branch_i     = br_v[mem_addr_o[PC_W-1:3]];
  assign branch_tgt_i = br_t[mem_addr_o[PC_W-1:3]];

  useq_ctrl #(.PC_W(PC_W)) dut_i (.*);

  always @(negedge clk) begin
    if (running_o && tn < 32) begin
      tr[tn] = mem_addr_o;
      lx[tn] = lower_exec_o;
      tn = tn + 1;
    end
    if (irq_o) irq_cnt = irq_cnt + 1;
  end

  // flags: {imm,end,mark,dbg,trap}
  function automatic logic [63:0] bun(input logic [4:0] f, input logic [31:0] lo);
    return {f, 27'h0, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < NB; i++) begin
      mem[i] = 64'h0; br_v[i] = 1'b0; br_t[i] = '0;
    end
  endtask

  task automatic put(input int unsigned a, input logic [63:0] b);
    mem[a[PC_W-1:3]] = b;
  endtask

  task automatic put_br(input int unsigned a, input int unsigned t);
    br_v[a[PC_W-1:3]] = 1'b1; br_t[a[PC_W-1:3]] = t[PC_W-1:0];
  endtask

  task automatic launch(input int unsigned a);
    @(negedge clk);
    tn = 0; irq_cnt = 0;
    start_addr_i = a[PC_W-1:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (running_o && n < 500) begin @(negedge clk); n++; end
    chk(!running_o, req, 64'(running_o), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_trace(input int n, input string req);
    chk(tn == n, req, 64'(tn), 64'(n));
    for (int i = 0; i < n && i < tn; i++)
      chk(tr[i] == ex[i], req, 64'(tr[i]), 64'(ex[i]));
  endtask

  task automatic t_reset();
    chk(!running_o && !irq_o && !dbg_stat_o && !trap_stat_o && !marker_o, "R9 reset flags",
        {59'd0, running_o, irq_o, dbg_stat_o, trap_stat_o, marker_o}, 64'd0);
    chk(imm_o == 32'h0, "R2 reset imm", 64'(imm_o), 64'd0);
  endtask

  task automatic t_linear_end();
    clear_prog();
    put('h40, bun(5'b00000, 0)); put('h48, bun(5'b01000, 0)); put('h50, bun(5'b00000, 0));
    launch('h43);
    chk(running_o && mem_addr_o == 'h40, "R9 start aligned", 64'(mem_addr_o), 64'h40);
    wait_idle("R3 stop");
    ex[0] = 'h40; ex[1] = 'h48; ex[2] = 'h50;
    cmp_trace(3, "R1/R3 linear trace");
  endtask

  task automatic t_immediate();
    clear_prog();
    put('h400, bun(5'b00000, 0));
    put('h408, bun(5'b10000, 32'hCAFE1234));
    put_br('h408, 'h600);
    put('h410, bun(5'b01000, 0));
    put('h418, bun(5'b00000, 0));
    launch('h400);
    wait_idle("R2 stop");
    ex[0] = 'h400; ex[1] = 'h408; ex[2] = 'h410; ex[3] = 'h418;
    cmp_trace(4, "R2 branch ignored under imm");
    chk(imm_o == 32'hCAFE1234, "R2 imm value", 64'(imm_o), 64'hCAFE1234);
    chk(lx[1] == 1'b0 && lx[0] == 1'b1, "R2 lower_exec", {62'd0, lx[0], lx[1]}, 64'b10);
  endtask

  task automatic t_branch();
    clear_prog();
    put_br('h480, 'h500);
    put('h500, bun(5'b01000, 0));
    launch('h480);
    wait_idle("R6 stop");
    ex[0] = 'h480; ex[1] = 'h488; ex[2] = 'h500; ex[3] = 'h508;
    cmp_trace(4, "R6 branch delay slot");
  endtask

  task automatic t_double_branch();
    clear_prog();
    put_br('h580, 'h700);
    put_br('h588, 'h740);
    put('h740, bun(5'b01000, 0));
    launch('h580);
    wait_idle("R7 stop");
    ex[0] = 'h580; ex[1] = 'h588; ex[2] = 'h700; ex[3] = 'h740; ex[4] = 'h748;
    cmp_trace(5, "R7 branch in delay slot");
  endtask

  task automatic t_events();
    clear_prog();
    put('h300, bun(5'b00010, 0));
    put('h308, bun(5'b01001, 0));
    flag_en_i = 2'b01;
    launch('h300);
    wait_idle("R4 stop");
    chk(dbg_stat_o == 1'b1, "R4 debug set", 64'(dbg_stat_o), 64'd1);
    chk(trap_stat_o == 1'b0, "R5 trap disabled", 64'(trap_stat_o), 64'd0);
    chk(irq_cnt == 1, "R4 irq count", 64'(irq_cnt), 64'd1);
    @(negedge clk) stat_clr_i = 3'b001;
    @(negedge clk) stat_clr_i = 3'b000;
    chk(dbg_stat_o == 1'b0, "R11 debug cleared", 64'(dbg_stat_o), 64'd0);
    flag_en_i = 2'b11;
    launch('h300);
    wait_idle("R5 stop");
    chk(dbg_stat_o && trap_stat_o, "R5 both set", {62'd0, dbg_stat_o, trap_stat_o}, 64'b11);
    chk(irq_cnt == 2, "R11 irq pulses", 64'(irq_cnt), 64'd2);
    @(negedge clk) stat_clr_i = 3'b010;
    @(negedge clk) stat_clr_i = 3'b000;
    chk(dbg_stat_o && !trap_stat_o, "R11 selective clear", {62'd0, dbg_stat_o, trap_stat_o}, 64'b10);
    @(negedge clk) stat_clr_i = 3'b001;
    @(negedge clk) stat_clr_i = 3'b000;
    flag_en_i = 2'b00;
    launch('h300);
    wait_idle("R4 stop");
    chk(!dbg_stat_o && !trap_stat_o && irq_cnt == 0, "R4 disabled no effect",
        {62'd0, dbg_stat_o, trap_stat_o}, 64'd0);
  endtask

  task automatic t_marker();
    clear_prog();
    put('h380, bun(5'b00100, 0));
    put('h388, bun(5'b01000, 0));
    launch('h380);
    wait_idle("R8 stop");
    chk(marker_o == 1'b1, "R8 marker sticky", 64'(marker_o), 64'd1);
    @(negedge clk) stat_clr_i = 3'b100;
    @(negedge clk) stat_clr_i = 3'b000;
    chk(marker_o == 1'b0, "R8 marker cleared", 64'(marker_o), 64'd0);
  endtask

  task automatic t_start_ignored();
    clear_prog();
    put('h128, bun(5'b01000, 0));
    put('h200, bun(5'b01000, 0));
    launch('h100);
    @(negedge clk);
    start_addr_i = 'h200; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    wait_idle("R10 stop");
    ex[0] = 'h100; ex[1] = 'h108; ex[2] = 'h110; ex[3] = 'h118;
    ex[4] = 'h120; ex[5] = 'h128; ex[6] = 'h130;
    cmp_trace(7, "R10 start while running");
  endtask

  task automatic t_wrap();
    clear_prog();
    put('h000, bun(5'b01000, 0));
    launch('hFF8);
    wait_idle("R12 stop");
    ex[0] = 'hFF8; ex[1] = 'h000; ex[2] = 'h008;
    cmp_trace(3, "R12 wrap");
  endtask

  initial begin
    clear_prog();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear_end();
    t_immediate();
    t_branch();
    t_double_branch();
    t_events();
    t_marker();
    t_start_ignored();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule